// File: doc/BRIEF.md
# Streaming Pixel Histogram Accumulator

This block counts how often each intensity level occurs in a video stream that arrives one pixel per clock. Each accepted pixel is reduced to a bin index, and the matching counter in an on-chip RAM is read, incremented with saturation and written back. Consecutive pixels that fall into the same bin are forwarded through the update pipeline, so none of them is lost. Counts keep growing across frames. Only a clear sweep sets them back to zero. A sweep runs by itself after reset and again whenever a clear is requested.

Once the pixel that closes a frame has been counted, the block opens a read window. While the window is open, a bin address is sampled on every cycle, and the count for that bin comes back two cycles later together with a one-cycle valid strobe. The window closes when a new frame starts or when a clear sweep begins. The frame interface uses only the frame-start marker, the frame-end marker and the valid flag. Line markers have no effect on the histogram and are not taken in.

Top module: `pixel_hist_accum`

## Requirements
- R1: The bin index is the top log2(BIN_CNT) bits of the pixel when the pixel is at least that wide, so the low pixel bits are dropped. A narrower pixel is zero-extended. For example, with BIN_CNT=32 and 8-bit pixels, 0xFF goes to bin 31 and 0x07 goes to bin 0.
- R2: Each counter is CNT_W bits wide and stops at 2^CNT_W-1 instead of wrapping to zero.
- R3: After reset, every bin is cleared over BIN_CNT cycles with no request from outside. Valid pixels during this sweep are not counted, and rd_ready stays low.
- R4: A clr_req raised outside a sweep starts a BIN_CNT-cycle sweep. rd_ready is low from the next cycle on, and pixels, addresses and clear requests are ignored until the sweep ends. After the sweep, every bin reads zero.
- R5: Counts accumulate over successive frames until a sweep clears them.
- R6: rd_ready rises after the second clock edge that follows the accepted pixel carrying ctl_ve and ctl_valid.
- R7: At every edge where rd_ready is high and no frame start arrives, rd_addr is accepted. bin_valid is then high for exactly one cycle after the second following edge, and bin_count holds that bin's count at that point.
- R8: An address accepted in the same cycle as clr_req returns the count as it was before the clear.
- R9: Pixels count only when ctl_valid is high. Inside the read window, a pixel is ignored unless it carries ctl_vs. Such a pixel closes the window, is counted, and the address in that cycle is not accepted.
- R10: Back-to-back pixels that fall into the same bin are all counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | PIX_W | Pixel intensity |
| ctl_vs | input | 1 | First pixel of a frame |
| ctl_ve | input | 1 | Last pixel of a frame |
| ctl_valid | input | 1 | Pixel and markers are valid |
| rd_addr | input | log2(BIN_CNT) | Bin to read during the read window |
| clr_req | input | 1 | Start a clear sweep of all bins |
| rd_ready | output | 1 | Read window open |
| bin_count | output | CNT_W | Count of the requested bin |
| bin_valid | output | 1 | bin_count is valid this cycle |

## Verification
The assertions assume that the stimulus follows the stream protocol. Frame-end markers come only on valid pixels, and no pixel stream runs while the read window is open, apart from the frame start that closes it. The forwarding and saturation properties also assume that every write comes from a pixel that was actually accepted. The bench therefore sends whole frames only outside the window and sweep. It sends stray pixels into those phases only to show that they are ignored, and it never overlaps a frame with a read.

// File: rtl/hist_pkg.sv
`timescale 1ns/1ps
package hist_pkg;
  typedef enum logic [1:0] {
    ST_SWEEP   = 2'd0,
    ST_COLLECT = 2'd1,
    ST_WINDOW  = 2'd2
  } hist_state_e;
endpackage

// File: rtl/hist_ram.sv
`timescale 1ns/1ps
module hist_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hist_rmw.sv
`timescale 1ns/1ps
module hist_rmw #(
  parameter int AW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          px_take,
  input  logic [AW-1:0] px_bin,
  input  logic [CW-1:0] rdata,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [CW-1:0] wr_data
);
  localparam logic [CW-1:0] CMAX = '1;

  logic          s1_v, s2_v;
  logic [AW-1:0] s1_bin, s2_bin;
  logic [CW-1:0] s2_val;
  logic [CW-1:0] base;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else begin
      s1_v <= px_take;
      s2_v <= s1_v;
    end
    s1_bin <= px_bin;
    s2_bin <= s1_bin;
    s2_val <= wr_data;
  end

  // the RAM read misses the write retiring in the same edge; take it from s2
  always_comb begin
    base    = (s2_v && s2_bin == s1_bin) ? s2_val : rdata;
    wr_data = (base == CMAX) ? CMAX : base + 1'b1;
    wr_en   = s1_v;
    wr_addr = s1_bin;
  end

  AST_NO_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_data != '0); // R2

  AST_SAME_BIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en) && wr_addr == $past(wr_addr) && $past(wr_data) != CMAX)
    |-> wr_data == $past(wr_data) + 1'b1); // R10
endmodule

// File: rtl/hist_ctrl.sv
`timescale 1ns/1ps
module hist_ctrl
  import hist_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_vs,
  input  logic          ctl_ve,
  input  logic          ctl_valid,
  input  logic          clr_req,
  output logic          sweeping,
  output logic [AW-1:0] sweep_idx,
  output logic          px_take,
  output logic          rd_take,
  output logic          window
);
  localparam logic [AW-1:0] LAST_IDX = '1;

  hist_state_e st;
  logic        ve_seen;
  logic        frame_start;

  always_comb begin
    frame_start = ctl_vs && ctl_valid;
    sweeping    = (st == ST_SWEEP);
    window      = (st == ST_WINDOW);
    px_take     = !sweeping && !clr_req && ctl_valid &&
                  ((st == ST_COLLECT) || ctl_vs);
    rd_take     = window && !frame_start;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_SWEEP;
      sweep_idx <= '0;
      ve_seen   <= 1'b0;
    end else if (st == ST_SWEEP) begin
      sweep_idx <= sweep_idx + 1'b1;
      ve_seen   <= 1'b0;
      if (sweep_idx == LAST_IDX) st <= ST_COLLECT;
    end else if (clr_req) begin
      st        <= ST_SWEEP;
      sweep_idx <= '0;
      ve_seen   <= 1'b0;
    end else begin
      ve_seen <= px_take && ctl_ve;
      if (ve_seen)                            st <= ST_WINDOW;
      else if (st == ST_WINDOW && frame_start) st <= ST_COLLECT;
    end
  end

  AST_CLEAR_CLOSES_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (clr_req && window) |=> !window); // R4

  AST_NO_COUNT_IN_SWEEP: assert property (@(posedge clk) disable iff (rst)
    ($past(sweeping) && sweeping) |-> !px_take); // R3
endmodule

// File: rtl/pixel_hist_accum.sv
`timescale 1ns/1ps
module pixel_hist_accum #(
  parameter int PIX_W   = 8,
  parameter int BIN_CNT = 256,
  parameter int CNT_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [PIX_W-1:0]           pix_in,
  input  logic                       ctl_vs,
  input  logic                       ctl_ve,
  input  logic                       ctl_valid,
  input  logic [$clog2(BIN_CNT)-1:0] rd_addr,
  input  logic                       clr_req,
  output logic                       rd_ready,
  output logic [CNT_W-1:0]           bin_count,
  output logic                       bin_valid
);
  localparam int AW = $clog2(BIN_CNT);

  logic [AW-1:0]    px_bin;
  logic             sweeping, px_take, rd_take;
  logic [AW-1:0]    sweep_idx;
  logic             upd_en;
  logic [AW-1:0]    upd_addr;
  logic [CNT_W-1:0] upd_data;
  logic             ram_we;
  logic [AW-1:0]    ram_waddr, ram_raddr;
  logic [CNT_W-1:0] ram_wdata, ram_rdata;
  logic             rq_v;

  generate
    if (PIX_W >= AW) begin : g_trunc
      assign px_bin = pix_in[PIX_W-1 -: AW];
    end else begin : g_pad
      assign px_bin = {{(AW-PIX_W){1'b0}}, pix_in};
    end
  endgenerate

  hist_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .ctl_vs(ctl_vs), .ctl_ve(ctl_ve),
    .ctl_valid(ctl_valid), .clr_req(clr_req), .sweeping(sweeping),
    .sweep_idx(sweep_idx), .px_take(px_take), .rd_take(rd_take),
    .window(rd_ready)
  );

  hist_rmw #(.AW(AW), .CW(CNT_W)) u_rmw (
    .clk(clk), .rst(rst), .px_take(px_take), .px_bin(px_bin),
    .rdata(ram_rdata), .wr_en(upd_en), .wr_addr(upd_addr),
    .wr_data(upd_data)
  );

  always_comb begin
    ram_we    = sweeping || upd_en;
    ram_waddr = sweeping ? sweep_idx : upd_addr;
    ram_wdata = sweeping ? '0 : upd_data;
    ram_raddr = rd_take ? rd_addr : px_bin;
  end

  hist_ram #(.AW(AW), .DW(CNT_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rq_v      <= 1'b0;
      bin_valid <= 1'b0;
      bin_count <= '0;
    end else begin
      rq_v      <= rd_take;
      bin_valid <= rq_v;
      if (rq_v) bin_count <= ram_rdata;
    end
  end

  AST_READY_LAT: assert property (@(posedge clk) disable iff (rst)
    (px_take && ctl_ve) ##1 !clr_req |=> rd_ready); // R6

  AST_READ_LAT: assert property (@(posedge clk) disable iff (rst)
    rd_take |-> ##2 bin_valid); // R7

  AST_VALID_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    bin_valid |-> $past(rd_take, 2)); // R7
endmodule

// File: tb/sim_pixel_hist_accum.sv
`timescale 1ns/1ps
module sim_pixel_hist_accum;
  localparam int PIX_W = 8;
  localparam int NB    = 32;
  localparam int CW    = 6;
  localparam int AW    = $clog2(NB);
  localparam int MAXC  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [PIX_W-1:0] pix = '0;
  logic          vs = 1'b0, ve = 1'b0, val = 1'b0, clr = 1'b0;
  logic [AW-1:0] raddr = '0;
  logic          rdy, bv;
  logic [CW-1:0] bcnt;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pixel_hist_accum #(.PIX_W(PIX_W), .BIN_CNT(NB), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .pix_in(pix), .ctl_vs(vs), .ctl_ve(ve),
    .ctl_valid(val), .rd_addr(raddr), .clr_req(clr), .rd_ready(rdy),
    .bin_count(bcnt), .bin_valid(bv)
  );

  // behavioural reference: 0 sweep, 1 collect, 2 window
  int mdl_bins [NB];
  int m_st, m_idx, m_d1, e_cnt;
  bit m_ve, m_v1, e_v, m_rdy, chk_en;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_idx = 0; m_ve = 0; m_v1 = 0; e_v = 0; m_rdy = 0; chk_en = 1;
    end else begin
      bit vsp, acc, pxok;
      int b;
      vsp = vs && val;
      e_v = m_v1; e_cnt = m_d1;
      acc = (m_st == 2) && !vsp;
      m_v1 = acc;
      if (acc) m_d1 = mdl_bins[raddr];
      if (m_st == 0) begin
        mdl_bins[m_idx] = 0;
        if (m_idx == NB - 1) m_st = 1;
        m_idx = (m_idx + 1) % NB;
        m_ve = 0;
      end else if (clr) begin
        m_st = 0; m_idx = 0; m_ve = 0;
      end else begin
        pxok = val && (m_st == 1 || vsp);
        if (pxok) begin
          b = int'(pix) >> (PIX_W - AW);
          if (mdl_bins[b] < MAXC) mdl_bins[b] = mdl_bins[b] + 1;
        end
        if (m_ve) m_st = 2;
        else if (m_st == 2 && vsp) m_st = 1;
        m_ve = pxok && ve;
      end
      m_rdy = (m_st == 2);
    end
  end

  always @(negedge clk) begin
    if (chk_en && !done) begin
      checks++;
      if (rdy !== m_rdy) begin
        fails++;
        $display("FAIL R6 rd_ready got %0d expected %0d at %0t", rdy, m_rdy, $time);
      end
      checks++;
      if (bv !== e_v) begin
        fails++;
        $display("FAIL R7 bin_valid got %0d expected %0d at %0t", bv, e_v, $time);
      end
      if (e_v) begin
        checks++;
        if (bcnt !== CW'(e_cnt)) begin
          fails++;
          $display("FAIL R5 bin_count got %0d expected %0d at %0t", bcnt, e_cnt, $time);
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive_px(input logic [7:0] v, input logic s, input logic e, input logic ok);
    @(negedge clk);
    pix = v; vs = s; ve = e; val = ok;
  endtask

  task automatic go_idle(input int n);
    repeat (n) begin
      @(negedge clk);
      val = 0; vs = 0; ve = 0;
    end
  endtask

  task automatic read_one(input int a, input int exp, input string tag);
    @(negedge clk);
    val = 0; vs = 0; ve = 0; raddr = AW'(a);
    @(negedge clk);
    @(negedge clk);
    chk({tag, " valid"}, int'(bv), 1);
    chk({tag, " count"}, int'(bcnt), exp);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R3 rd_ready in reset", int'(rdy), 0);
    chk("R3 bin_valid in reset", int'(bv), 0);
    @(negedge clk); rst = 0;
    // R3: pixels during the startup sweep are not counted
    for (int i = 0; i < 20; i++) drive_px(8'h48, 1'b0, 1'b0, 1'b1);
    chk("R3 rd_ready during sweep", int'(rdy), 0);
    go_idle(20);

    // frame 1: R1 truncation, R10 same-bin bursts, R9 invalid ignored
    drive_px(8'h00, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) drive_px(8'h48, 1'b0, 1'b0, 1'b1);
    drive_px(8'h49, 1'b0, 1'b0, 1'b1);
    drive_px(8'h50, 1'b0, 1'b0, 1'b0);
    drive_px(8'hFF, 1'b0, 1'b0, 1'b1);
    drive_px(8'h07, 1'b0, 1'b1, 1'b1);
    @(negedge clk); val = 0; ve = 0;
    chk("R6 rd_ready one cycle after frame end", int'(rdy), 0);
    @(negedge clk);
    chk("R6 rd_ready two cycles after frame end", int'(rdy), 1);
    read_one(9, 5, "R10 bin 9");
    read_one(0, 2, "R1 bin 0");
    read_one(31, 1, "R1 bin 31");
    read_one(10, 0, "R9 bin 10");

    // frame 2 inside window: R9 stray pixel ignored, frame start counted; R5
    drive_px(8'h48, 1'b0, 1'b0, 1'b1);
    drive_px(8'h48, 1'b1, 1'b0, 1'b1);
    drive_px(8'h48, 1'b0, 1'b1, 1'b1);
    chk("R9 window closed by frame start", int'(rdy), 0);
    go_idle(3);
    read_one(9, 7, "R5 bin 9 accumulated");

    // R2 saturation: 70 pixels into bin 5
    drive_px(8'h28, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 68; i++) drive_px(8'h28, 1'b0, 1'b0, 1'b1);
    drive_px(8'h28, 1'b0, 1'b1, 1'b1);
    go_idle(3);
    read_one(5, MAXC, "R2 bin 5 saturated");

    // R8: last read together with the clear request
    @(negedge clk); raddr = 5'd9; clr = 1;
    @(negedge clk); clr = 0; pix = 8'h48; val = 1;
    @(negedge clk);
    chk("R8 valid with clear", int'(bv), 1);
    chk("R8 count with clear", int'(bcnt), 7);
    chk("R4 window closed by clear", int'(rdy), 0);
    // R4: inputs ignored during the sweep
    for (int i = 0; i < 20; i++) begin
      drive_px(8'h48, 1'b0, 1'b1, 1'b1);
      clr = 1;
    end
    @(negedge clk); clr = 0;
    go_idle(20);
    drive_px(8'h28, 1'b1, 1'b1, 1'b1);
    go_idle(3);
    read_one(5, 1, "R4 bin 5 after clear");
    read_one(9, 0, "R4 bin 9 after clear");
    go_idle(4);
    finish_run();
  end
endmodule